// File: doc/BRIEF.md
# Windowed Address Generator with Axis Mirroring

This block produces the memory address sequence for one port of a field buffer. The frame is addressed as `row * pitch + column`. When window mode is active, a rectangular sub-region of the frame is traversed one word per enabled cycle. Traversal can run backwards along the horizontal axis, the vertical axis, or both, so that a stored window comes out flipped. When window mode is inactive, the port walks the address space linearly from zero.

The window geometry is written into a bank of pending registers through a parallel address/data/strobe interface. These values sit idle until the port's restart pulse. On that pulse they are copied, together with the mode input, into the working set that drives traversal. Rewriting the geometry in the middle of a frame therefore cannot disturb the window currently in progress.

All outputs are registered. Each output describes the word at which the port currently stands: its address, whether it lies inside an active traversal, and whether it is the final word of a row or of the whole window.

Top module: `win_addr_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `valid_o`, `eol_o` and `eow_o` are 0 and `addr_o` is 0. No traversal is active until the first `port_rst`.
- R2: Writing with `cfg_we` high stores `cfg_data` in a pending register. The register is selected by `cfg_addr`: 0 column low, 1 column high, 2 row low, 3 row high, 4 pitch, 5 mirror (bit 0 horizontal, bit 1 vertical). Pending values affect the outputs only after the next `port_rst`. A write in the same cycle as `port_rst` takes effect at the following `port_rst`.
- R3: If `win_mode_n` is high when `port_rst` is sampled, the port runs linearly. `addr_o` starts at 0 and rises by 1 (modulo 2^AW) on each `port_en` cycle. `valid_o` stays 1, and `eol_o` and `eow_o` stay 0.
- R4: In window mode, `addr_o` equals row * pitch + column, truncated to AW bits. Position and outputs change only on cycles with `port_en` or `port_rst` high.
- R5: Without mirroring, the column runs from column low up to column high. `eol_o` marks the column-high word. The next step returns to column low and moves one row down. Rows run from row low to row high.
- R6: With horizontal mirroring, each row starts at column high and steps down to column low, and `eol_o` marks the column-low word.
- R7: With vertical mirroring, the first row is row high and rows step down to row low.
- R8: `eow_o` is high only on the final word of the window, together with `eol_o`. A `port_en` on that word drops `valid_o` to 0. The position and `addr_o` then hold until the next `port_rst`.
- R9: A high bound programmed below its low bound is taken as equal to the low bound. This gives a one-word-wide extent on that axis at the low bound.
- R10: `port_rst` takes priority over `port_en`. In the cycle after a `port_rst`, the outputs show the first word of the new traversal, even if the previous one was unfinished.
- R11: `win_mode_n` is sampled only at `port_rst`. Changing it between restart pulses has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Pending-register write strobe |
| cfg_addr | input | 3 | Pending-register select |
| cfg_data | input | DW | Pending-register write data |
| win_mode_n | input | 1 | Low selects window traversal, sampled at `port_rst` |
| port_rst | input | 1 | Restart pulse: load pending setup, go to first word |
| port_en | input | 1 | Advance to the next word |
| addr_o | output | AW | Address of the current word |
| valid_o | output | 1 | Current word belongs to an active traversal |
| eol_o | output | 1 | Current word is the last of its row |
| eow_o | output | 1 | Current word is the last of the window |

## Verification
The bench targets the row wrap under each mirror combination. A wrong reload value there would make the second row start at the far edge, or continue past it. Mid-frame geometry writes and `win_mode_n` toggles are followed by idle and enabled cycles, to catch a design that lets pending or unsampled values leak into the live traversal. Inverted bounds, a restart pulse coinciding with an enable, and enables after the final word are aimed at designs that run backwards past the low bound, honour the enable over the restart, or keep counting after the window closes.

// File: rtl/wag_pkg.sv
package wag_pkg;

  typedef enum logic [2:0] {
    REG_COL_LO = 3'd0,
    REG_COL_HI = 3'd1,
    REG_ROW_LO = 3'd2,
    REG_ROW_HI = 3'd3,
    REG_PITCH  = 3'd4,
    REG_MIRROR = 3'd5
  } wag_reg_e;

endpackage

// File: rtl/wag_setup_regs.sv
module wag_setup_regs
  import wag_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 10,
  parameter int PW = 11,
  parameter int DW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_data,
  input  logic          load,
  output logic [XW-1:0] stg_xlo,
  output logic [XW-1:0] stg_xhi,
  output logic [YW-1:0] stg_ylo,
  output logic [YW-1:0] stg_yhi,
  output logic [PW-1:0] stg_pitch,
  output logic          stg_mx,
  output logic          stg_my,
  output logic [XW-1:0] wrk_xlo,
  output logic [XW-1:0] wrk_xhi,
  output logic [YW-1:0] wrk_ylo,
  output logic [YW-1:0] wrk_yhi,
  output logic [PW-1:0] wrk_pitch,
  output logic          wrk_mx,
  output logic          wrk_my
);

  logic [XW-1:0] pend_xlo, pend_xhi;
  logic [YW-1:0] pend_ylo, pend_yhi;
  logic [PW-1:0] pend_pitch;
  logic [1:0]    pend_mir;

  // Staged view: pending values with inverted bounds clamped (R9)
  always_comb begin
    stg_xlo   = pend_xlo;
    stg_xhi   = (pend_xhi < pend_xlo) ? pend_xlo : pend_xhi;
    stg_ylo   = pend_ylo;
    stg_yhi   = (pend_yhi < pend_ylo) ? pend_ylo : pend_yhi;
    stg_pitch = pend_pitch;
    stg_mx    = pend_mir[0];
    stg_my    = pend_mir[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_xlo <= '0; pend_xhi <= '0; pend_ylo <= '0; pend_yhi <= '0;
      pend_pitch <= '0; pend_mir <= '0;
      wrk_xlo <= '0; wrk_xhi <= '0; wrk_ylo <= '0; wrk_yhi <= '0;
      wrk_pitch <= '0; wrk_mx <= 1'b0; wrk_my <= 1'b0;
    end else begin
      if (load) begin
        wrk_xlo   <= stg_xlo;
        wrk_xhi   <= stg_xhi;
        wrk_ylo   <= stg_ylo;
        wrk_yhi   <= stg_yhi;
        wrk_pitch <= stg_pitch;
        wrk_mx    <= stg_mx;
        wrk_my    <= stg_my;
      end
      if (cfg_we) begin
        case (cfg_addr)
          REG_COL_LO: pend_xlo   <= cfg_data[XW-1:0];
          REG_COL_HI: pend_xhi   <= cfg_data[XW-1:0];
          REG_ROW_LO: pend_ylo   <= cfg_data[YW-1:0];
          REG_ROW_HI: pend_yhi   <= cfg_data[YW-1:0];
          REG_PITCH:  pend_pitch <= cfg_data[PW-1:0];
          REG_MIRROR: pend_mir   <= cfg_data[1:0];
          default: ;
        endcase
      end
    end
  end

  // R9: live bounds are never inverted
  a_r9_bounds_ordered: assert property (@(posedge clk) disable iff (rst)
    (wrk_xhi >= wrk_xlo) && (wrk_yhi >= wrk_ylo));

  // R2: live setup changes only on a restart pulse
  a_r2_live_stable: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(wrk_xlo) && $stable(wrk_xhi) && $stable(wrk_pitch)
               && $stable(wrk_mx) && $stable(wrk_my)));

endmodule

// File: rtl/wag_axis.sv
module wag_axis #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] stg_lo,
  input  logic [W-1:0] stg_hi,
  input  logic         stg_mir,
  input  logic [W-1:0] wrk_lo,
  input  logic [W-1:0] wrk_hi,
  input  logic         wrk_mir,
  output logic [W-1:0] pos_nxt,
  output logic         last_nxt,
  output logic         at_last
);

  logic [W-1:0] pos_q;
  logic [W-1:0] first_w, final_w, first_s, final_s;

  always_comb begin
    first_w = wrk_mir ? wrk_hi : wrk_lo;
    final_w = wrk_mir ? wrk_lo : wrk_hi;
    first_s = stg_mir ? stg_hi : stg_lo;
    final_s = stg_mir ? stg_lo : stg_hi;
    at_last = (pos_q == final_w);
    if (load)
      pos_nxt = first_s;
    else if (step)
      pos_nxt = at_last ? first_w : (wrk_mir ? pos_q - W'(1) : pos_q + W'(1));
    else
      pos_nxt = pos_q;
    last_nxt = load ? (first_s == final_s) : (pos_nxt == final_w);
  end

  always_ff @(posedge clk) begin
    if (rst) pos_q <= '0;
    else     pos_q <= pos_nxt;
  end

  // R6 / R7: a step inside the span moves one position in the mirror direction
  a_r6_r7_step_dir: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !at_last) |=>
      (pos_q == ($past(wrk_mir) ? $past(pos_q) - W'(1) : $past(pos_q) + W'(1))));

  // R10: a restart places the axis at its new first position
  a_r10_load_first: assert property (@(posedge clk) disable iff (rst)
    load |=> (pos_q == ($past(stg_mir) ? $past(stg_hi) : $past(stg_lo))));

endmodule

// File: rtl/wag_out.sv
module wag_out #(
  parameter int XW = 10,
  parameter int YW = 10,
  parameter int PW = 11,
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_nxt,
  input  logic          lin_nxt,
  input  logic [AW-1:0] lcnt_nxt,
  input  logic [XW-1:0] x_nxt,
  input  logic [YW-1:0] y_nxt,
  input  logic [PW-1:0] pitch_nxt,
  input  logic          xl_nxt,
  input  logic          yl_nxt,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic          eol_o,
  output logic          eow_o
);

  localparam int FW = YW + PW + 1;

  logic [FW-1:0] win_addr;
  logic [AW-1:0] addr_d;
  logic          eol_d;

  always_comb begin
    win_addr = FW'(y_nxt) * FW'(pitch_nxt) + FW'(x_nxt);
    addr_d   = lin_nxt ? lcnt_nxt : AW'(win_addr);
    eol_d    = act_nxt && !lin_nxt && xl_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      valid_o <= 1'b0;
      eol_o   <= 1'b0;
      eow_o   <= 1'b0;
    end else begin
      addr_o  <= addr_d;
      valid_o <= act_nxt;
      eol_o   <= eol_d;
      eow_o   <= eol_d && yl_nxt;
    end
  end

  // R8: window end always coincides with a row end
  a_r8_eow_has_eol: assert property (@(posedge clk) disable iff (rst)
    eow_o |-> (eol_o && valid_o));

endmodule

// File: rtl/win_addr_gen.sv
module win_addr_gen #(
  parameter int XW = 10,
  parameter int YW = 10,
  parameter int PW = 11,
  parameter int AW = 20,
  parameter int DW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_data,
  input  logic          win_mode_n,
  input  logic          port_rst,
  input  logic          port_en,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic          eol_o,
  output logic          eow_o
);

  logic [XW-1:0] stg_xlo, stg_xhi, wrk_xlo, wrk_xhi, x_nxt;
  logic [YW-1:0] stg_ylo, stg_yhi, wrk_ylo, wrk_yhi, y_nxt;
  logic [PW-1:0] stg_pitch, wrk_pitch, pitch_nxt;
  logic          stg_mx, stg_my, wrk_mx, wrk_my;
  logic          x_last, y_last, xl_nxt, yl_nxt;
  logic          act_q, lin_q, act_nxt, lin_nxt;
  logic [AW-1:0] lcnt_q, lcnt_nxt;
  logic          win_go, x_step, y_step;

  wag_setup_regs #(.XW(XW), .YW(YW), .PW(PW), .DW(DW)) u_setup (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .load(port_rst),
    .stg_xlo(stg_xlo), .stg_xhi(stg_xhi), .stg_ylo(stg_ylo), .stg_yhi(stg_yhi),
    .stg_pitch(stg_pitch), .stg_mx(stg_mx), .stg_my(stg_my),
    .wrk_xlo(wrk_xlo), .wrk_xhi(wrk_xhi), .wrk_ylo(wrk_ylo), .wrk_yhi(wrk_yhi),
    .wrk_pitch(wrk_pitch), .wrk_mx(wrk_mx), .wrk_my(wrk_my)
  );

  always_comb begin
    win_go    = port_en && act_q && !lin_q && !port_rst;
    x_step    = win_go && !(x_last && y_last);
    y_step    = win_go && x_last && !y_last;
    act_nxt   = port_rst ? 1'b1 : ((win_go && x_last && y_last) ? 1'b0 : act_q);
    lin_nxt   = port_rst ? win_mode_n : lin_q;
    lcnt_nxt  = port_rst ? '0 : ((port_en && act_q && lin_q) ? lcnt_q + AW'(1) : lcnt_q);
    pitch_nxt = port_rst ? stg_pitch : wrk_pitch;
  end

  wag_axis #(.W(XW)) u_col (
    .clk(clk), .rst(rst), .load(port_rst), .step(x_step),
    .stg_lo(stg_xlo), .stg_hi(stg_xhi), .stg_mir(stg_mx),
    .wrk_lo(wrk_xlo), .wrk_hi(wrk_xhi), .wrk_mir(wrk_mx),
    .pos_nxt(x_nxt), .last_nxt(xl_nxt), .at_last(x_last)
  );

  wag_axis #(.W(YW)) u_row (
    .clk(clk), .rst(rst), .load(port_rst), .step(y_step),
    .stg_lo(stg_ylo), .stg_hi(stg_yhi), .stg_mir(stg_my),
    .wrk_lo(wrk_ylo), .wrk_hi(wrk_yhi), .wrk_mir(wrk_my),
    .pos_nxt(y_nxt), .last_nxt(yl_nxt), .at_last(y_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      lin_q  <= 1'b0;
      lcnt_q <= '0;
    end else begin
      act_q  <= act_nxt;
      lin_q  <= lin_nxt;
      lcnt_q <= lcnt_nxt;
    end
  end

  wag_out #(.XW(XW), .YW(YW), .PW(PW), .AW(AW)) u_out (
    .clk(clk), .rst(rst), .act_nxt(act_nxt), .lin_nxt(lin_nxt),
    .lcnt_nxt(lcnt_nxt), .x_nxt(x_nxt), .y_nxt(y_nxt), .pitch_nxt(pitch_nxt),
    .xl_nxt(xl_nxt), .yl_nxt(yl_nxt),
    .addr_o(addr_o), .valid_o(valid_o), .eol_o(eol_o), .eow_o(eow_o)
  );

  // R1: reset leaves the port idle at address zero
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!valid_o && !eol_o && !eow_o && addr_o == '0));

  // R4: without enable or restart nothing moves
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!port_en && !port_rst) |=> ($stable(addr_o) && $stable(valid_o) && $stable(eol_o)));

  // R8: enabling the final word closes the traversal
  a_r8_close: assert property (@(posedge clk) disable iff (rst)
    (valid_o && eow_o && port_en && !port_rst) |=> !valid_o);

  // R3: linear traversal never flags row or window ends
  a_r3_lin_no_marks: assert property (@(posedge clk) disable iff (rst)
    lin_q |-> (!eol_o && !eow_o));

endmodule

// File: tb/win_addr_gen_test.sv
module win_addr_gen_test;

  localparam int TCK = 10;
  localparam int XW = 10, YW = 10, PW = 11, AW = 20, DW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [DW-1:0] cfg_data = '0;
  logic win_mode_n = 1'b0;
  logic port_rst = 1'b0;
  logic port_en = 1'b0;
  logic [AW-1:0] addr_o;
  logic valid_o, eol_o, eow_o;

  always #(TCK/2) clk = ~clk;

  win_addr_gen #(.XW(XW), .YW(YW), .PW(PW), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .win_mode_n(win_mode_n), .port_rst(port_rst), .port_en(port_en),
    .addr_o(addr_o), .valid_o(valid_o), .eol_o(eol_o), .eow_o(eow_o)
  );

  int vecs = 0, errs = 0;
  string tag = "R1";

  // reference state
  int sx0, sx1, sy0, sy1, sp, smir;
  int wx0, wx1, wy0, wy1, wp, wmx, wmy;
  int mact, mlin, mcnt, mx, my;

  function automatic int xfinal(); return wmx ? wx0 : wx1; endfunction
  function automatic int yfinal(); return wmy ? wy0 : wy1; endfunction
  function automatic int exp_addr();
    longint a;
    a = mlin ? mcnt : longint'(my) * wp + mx;
    return int'(a & ((64'd1 << AW) - 1));
  endfunction

  task automatic model_step(input bit r, input bit we, input int a, input int d,
                            input bit wmn, input bit pr, input bit pe);
    if (r) begin
      sx0 = 0; sx1 = 0; sy0 = 0; sy1 = 0; sp = 0; smir = 0;
      wx0 = 0; wx1 = 0; wy0 = 0; wy1 = 0; wp = 0; wmx = 0; wmy = 0;
      mact = 0; mlin = 0; mcnt = 0; mx = 0; my = 0;
      return;
    end
    if (pr) begin
      wx0 = sx0; wx1 = (sx1 < sx0) ? sx0 : sx1;
      wy0 = sy0; wy1 = (sy1 < sy0) ? sy0 : sy1;
      wp = sp; wmx = smir & 1; wmy = (smir >> 1) & 1;
      mact = 1; mlin = wmn; mcnt = 0;
      mx = wmx ? wx1 : wx0; my = wmy ? wy1 : wy0;
    end else if (pe && mact) begin
      if (mlin) mcnt = (mcnt + 1) & ((1 << AW) - 1);
      else if (mx == xfinal() && my == yfinal()) mact = 0;
      else if (mx == xfinal()) begin
        mx = wmx ? wx1 : wx0;
        my = wmy ? my - 1 : my + 1;
      end else mx = wmx ? mx - 1 : mx + 1;
    end
    if (we) begin
      case (a)
        0: sx0 = d & 1023;
        1: sx1 = d & 1023;
        2: sy0 = d & 1023;
        3: sy1 = d & 1023;
        4: sp  = d & 2047;
        5: smir = d & 3;
        default: ;
      endcase
    end
  endtask

  task automatic tick(input bit we, input int a, input int d,
                      input bit wmn, input bit pr, input bit pe);
    int ea; bit ev, el, ew;
    @(negedge clk);
    cfg_we = we; cfg_addr = 3'(a); cfg_data = DW'(d);
    win_mode_n = wmn; port_rst = pr; port_en = pe;
    @(posedge clk);
    #1;
    model_step(rst, we, a, d, wmn, pr, pe);
    ea = exp_addr();
    ev = mact != 0;
    el = ev && !mlin && mx == xfinal();
    ew = el && my == yfinal();
    vecs++;
    if (int'(addr_o) != ea || valid_o != ev || eol_o != el || eow_o != ew) begin
      errs++;
      $display("FAIL %s: addr=%0d valid=%0b eol=%0b eow=%0b, expected addr=%0d valid=%0b eol=%0b eow=%0b",
               tag, addr_o, valid_o, eol_o, eow_o, ea, ev, el, ew);
    end
  endtask

  task automatic wr(input int a, input int d, input bit wmn);
    tick(1'b1, a, d, wmn, 1'b0, 1'b0);
  endtask

  task automatic setup(input int x0, input int x1, input int y0, input int y1,
                       input int p, input int mir);
    wr(0, x0, 1'b0); wr(1, x1, 1'b0); wr(2, y0, 1'b0);
    wr(3, y1, 1'b0); wr(4, p, 1'b0); wr(5, mir, 1'b0);
  endtask

  task automatic run(input int n, input bit wmn);
    for (int i = 0; i < n; i++) tick(1'b0, 0, 0, wmn, 1'b0, 1'b1);
  endtask

  task automatic restart(input bit wmn);
    tick(1'b0, 0, 0, wmn, 1'b1, 1'b0);
  endtask

  initial begin
    #(TCK * 150000);
    errs++;
    $display("FAIL R4: watchdog, actual run still busy, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'd1234);
    // R1: reset state
    tag = "R1";
    tick(0, 0, 0, 0, 0, 0); tick(0, 0, 0, 0, 1, 1);
    rst = 1'b0;
    tick(0, 0, 0, 0, 0, 0); tick(0, 0, 0, 0, 0, 1);

    // R2 / R5: plain window 2..4 x 1..2, pitch 10
    tag = "R2"; setup(2, 4, 1, 2, 10, 0); restart(1'b0);
    tag = "R5"; run(6, 1'b0);
    // R8: enables past the final word hold
    tag = "R8"; run(3, 1'b0);
    // R2: pending write mid-frame does not disturb the live window
    tag = "R2"; restart(1'b0); run(2, 1'b0);
    wr(1, 7, 1'b0); wr(4, 20, 1'b0);
    tick(0, 0, 0, 0, 0, 0); run(4, 1'b0);
    // R2: write coinciding with restart lands at the following restart
    tick(1'b1, 4, 30, 1'b0, 1'b1, 1'b0); run(3, 1'b0);
    restart(1'b0); run(3, 1'b0);

    // R6 / R7: mirror combinations
    setup(1, 3, 2, 4, 8, 1);
    tag = "R6"; restart(1'b0); run(10, 1'b0);
    wr(5, 2, 1'b0);
    tag = "R7"; restart(1'b0); run(10, 1'b0);
    wr(5, 3, 1'b0);
    tag = "R6"; restart(1'b0); run(10, 1'b0);

    // R9: inverted bounds clamp to one word wide
    tag = "R9"; setup(5, 2, 3, 1, 16, 0); restart(1'b0); run(3, 1'b0);
    wr(5, 3, 1'b0); restart(1'b0); run(2, 1'b0);

    // R10: restart beats enable, also mid-window
    tag = "R10"; setup(0, 3, 0, 3, 4, 0); restart(1'b0); run(5, 1'b0);
    tick(0, 0, 0, 0, 1, 1); run(2, 1'b0);

    // R3: linear mode
    tag = "R3"; restart(1'b1); run(5, 1'b1);
    tick(0, 0, 0, 1, 0, 0); run(3, 1'b1);
    // R11: mode input changes between restarts are ignored
    tag = "R11"; run(4, 1'b0);
    restart(1'b0); run(3, 1'b1); tick(0, 0, 0, 1, 0, 0); run(2, 1'b0);

    // R4: constrained random mix
    tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      int k, a, d;
      bit wmn, pr, pe, we;
      k = int'($urandom_range(0, 99));
      pr = (k < 8);
      we = (k >= 8 && k < 24);
      pe = ($urandom_range(0, 99) < 65);
      wmn = ($urandom_range(0, 99) < 20);
      a = int'($urandom_range(0, 6));
      d = (a == 4) ? int'($urandom_range(0, 40)) : int'($urandom_range(0, 12));
      if (i % 1500 == 1499) begin
        rst = 1'b1; tick(0, 0, 0, 0, 0, 0); rst = 1'b0;
      end else tick(we, a, d, wmn, pr, pe);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule